// File: doc/BRIEF.md
# Packed Narrow-Register APB Slave

This block is a 32-bit APB4 slave that holds a fixed set of control registers, some narrower than the bus, packed side by side into bus words. Word 0 carries four 8-bit registers (one per byte offset 0..3). Word 1 carries two 16-bit registers at byte offsets 4 and 6. Word 2 is a single 32-bit register whose bit 0 is a self-clearing pulse field. A single bus access can write several packed registers at once. A read collects them into one bus-width response.

The bus layer turns the byte address into a word index, so the two low address bits never reach the decoder. Inside the block all data is little-endian: byte offset k sits on lane k. Setting `BIG_ENDIAN` makes the bus layer reverse the byte lanes of write data, the strobe bits and read data. The 16-bit register at offset 6 can also be loaded by hardware. The current register contents are driven out to the surrounding logic.

Top module: `npk_apb_regs`

## Requirements
- R1: `pready` is 1 in every cycle, so every access finishes with zero wait states.
- R2: In an access phase, `pslverr` is 1 exactly when the word index `paddr[ADDR_W-1:2]` is 3 or greater (byte address 0xC and up). A write to such an address changes no register.
- R3: Address bits [1:0] are ignored. Any byte address inside a word selects that whole word, so 0x3 acts as 0x0 and 0x5 as 0x4.
- R4: A write to word 0 updates the 8-bit register at offset i from `pwdata[8i+7:8i]` exactly when `pstrb[i]` is 1. Any mix of strobes writes that mix of registers in the same cycle; for example 4'b0101 writes only offsets 0 and 2.
- R5: A write to word 1 updates the offset-4 register from `pwdata[15:0]` only when `pstrb[1:0]` is 2'b11. It updates the offset-6 register from `pwdata[31:16]` only when `pstrb[3:2]` is 2'b11. A single strobe bit writes nothing.
- R6: A write to word 2 updates the 32-bit register only when `pstrb` is 4'b1111. Any other strobe pattern leaves it unchanged.
- R7: A read returns {off3,off2,off1,off0} for word 0, {off6,off4} for word 1, and the word-2 register with bit 0 read as 0. `prdata` is 0 whenever `psel` is low, `pwrite` is high, or the address is out of range.
- R8: A full-strobe write to word 2 with `pwdata[0]`=1 makes `word_q[0]` high in the following cycle only. It is 0 again one cycle later.
- R9: When `hw_valid` is 1, the offset-6 register loads `hw_next` on the clock edge, unless a software write to that register lands on the same edge. The software write takes priority.
- R10: With `BIG_ENDIAN`=1, the bus layer reverses byte lanes: `pwdata` lane j and `pstrb[j]` map to internal lane 3-j, and `prdata` lane j carries internal lane 3-j.
- R11: `presetn` low clears every register and the pulse field to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Write byte strobes |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Out-of-range access error |
| hw_valid | input | 1 | Hardware load enable for the offset-6 register |
| hw_next | input | HALF_W | Hardware load value |
| byte_q | output | DATA_W | The four 8-bit registers, offset k on lane k |
| half_q | output | DATA_W | The two 16-bit registers, offset 4 low |
| word_q | output | DATA_W | 32-bit register; bit 0 is the pulse |

## Verification
Every register is visible on `byte_q`, `half_q` and `word_q`. A wrong strobe decode or a wrong priority therefore shows up as a mismatch on the clock edge right after the faulty write or hardware load. Lane placement errors in readback or in the byte swap appear on `prdata` in the same access phase. Two instances run side by side, one of each endianness, and receive logically identical traffic, so any swap fault shows up as a difference between them. A pulse that fails to clear shows up one cycle late on `word_q[0]`.

// File: rtl/npk_pkg.sv
`timescale 1ns/1ps
package npk_pkg;
   localparam int BUS_W       = 32;
   localparam int LANES       = BUS_W / 8;
   localparam int N_BYTE_REGS = 4;
   localparam int N_HALF_REGS = 2;
   localparam int N_WORDS     = 3;
   localparam int HW_HALF_IDX = 1;
   localparam int WORD_BYTES  = 0;
   localparam int WORD_HALVES = 1;
   localparam int WORD_FULL   = 2;

   typedef struct packed {
      logic [N_BYTE_REGS-1:0] b;
      logic [N_HALF_REGS-1:0] h;
      logic                   w;
   } npk_stb_t;
endpackage

// File: rtl/npk_busif.sv
`timescale 1ns/1ps
module npk_busif #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [ADDR_W-1:0]   paddr,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [DATA_W-1:0]   pwdata,
   input  logic [DATA_W/8-1:0] pstrb,
   input  logic [DATA_W-1:0]   rdata_le,
   output logic [ADDR_W-3:0]   widx,
   output logic                acc_wr,
   output logic                rd_sel,
   output logic [DATA_W-1:0]   wdata_le,
   output logic [DATA_W/8-1:0] strb_le,
   output logic [DATA_W-1:0]   prdata
);
   localparam int NL = DATA_W / 8;

   // word alignment: the low two address bits never leave this stage
   assign widx   = paddr[ADDR_W-1:2];
   assign acc_wr = psel & penable & pwrite;
   assign rd_sel = psel & ~pwrite;

   for (genvar i = 0; i < NL; i++) begin : g_lane
      if (BIG_ENDIAN) begin : g_swap
         assign wdata_le[8*i +: 8] = pwdata[8*(NL-1-i) +: 8];
         assign strb_le[i]         = pstrb[NL-1-i];
         assign prdata[8*i +: 8]   = rdata_le[8*(NL-1-i) +: 8];
      end else begin : g_pass
         assign wdata_le[8*i +: 8] = pwdata[8*i +: 8];
         assign strb_le[i]         = pstrb[i];
         assign prdata[8*i +: 8]   = rdata_le[8*i +: 8];
      end
   end
endmodule

// File: rtl/npk_decode.sv
`timescale 1ns/1ps
module npk_decode
   import npk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-3:0]   widx,
   input  logic                acc_wr,
   input  logic [DATA_W/8-1:0] strb,
   output logic [N_WORDS-1:0]  wsel,
   output logic                oob,
   output npk_stb_t            stb
);
   localparam int IW = ADDR_W - 2;
   localparam logic [IW-1:0] LAST_IDX = IW'(N_WORDS - 1);

   for (genvar k = 0; k < N_WORDS; k++) begin : g_wsel
      assign wsel[k] = (widx == IW'(k));
   end
   assign oob = (widx > LAST_IDX);

   // one access may raise several strobes when registers share a word
   for (genvar i = 0; i < N_BYTE_REGS; i++) begin : g_bstb
      assign stb.b[i] = acc_wr & wsel[WORD_BYTES] & strb[i];
   end
   for (genvar j = 0; j < N_HALF_REGS; j++) begin : g_hstb
      assign stb.h[j] = acc_wr & wsel[WORD_HALVES] & (&strb[2*j +: 2]);
   end
   assign stb.w = acc_wr & wsel[WORD_FULL] & (&strb);
endmodule

// File: rtl/npk_regs.sv
`timescale 1ns/1ps
module npk_regs
   import npk_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  npk_stb_t          stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic              hw_valid,
   input  logic [HALF_W-1:0] hw_next,
   output logic [DATA_W-1:0] byte_q,
   output logic [DATA_W-1:0] half_q,
   output logic [DATA_W-1:0] word_q
);
   logic [N_BYTE_REGS-1:0][7:0]        byte_r;
   logic [N_HALF_REGS-1:0][HALF_W-1:0] half_r;
   logic [DATA_W-1:1]                  word_r;
   logic                               pulse_r;

   for (genvar i = 0; i < N_BYTE_REGS; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        byte_r[i] <= '0;
         else if (stb.b[i]) byte_r[i] <= wdata[8*i +: 8];
      end
   end

   for (genvar j = 0; j < N_HALF_REGS; j++) begin : g_half
      if (j == HW_HALF_IDX) begin : g_hw
         // software first, hardware next value as the final else
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        half_r[j] <= '0;
            else if (stb.h[j]) half_r[j] <= wdata[HALF_W*j +: HALF_W];
            else if (hw_valid) half_r[j] <= hw_next;
         end
      end else begin : g_sw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        half_r[j] <= '0;
            else if (stb.h[j]) half_r[j] <= wdata[HALF_W*j +: HALF_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_r <= '0;
      else if (stb.w) word_r <= wdata[DATA_W-1:1];
   end

   // single-pulse: lowest priority branch clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pulse_r <= 1'b0;
      else if (stb.w) pulse_r <= wdata[0];
      else            pulse_r <= 1'b0;
   end

   assign byte_q = byte_r;
   assign half_q = half_r;
   assign word_q = {word_r, pulse_r};
endmodule

// File: rtl/npk_rdmux.sv
`timescale 1ns/1ps
module npk_rdmux
   import npk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic               rd_sel,
   input  logic               oob,
   input  logic [N_WORDS-1:0] wsel,
   input  logic [DATA_W-1:0]  byte_q,
   input  logic [DATA_W-1:0]  half_q,
   input  logic [DATA_W-1:1]  word_hi,
   output logic [DATA_W-1:0]  rdata_le
);
   logic [N_WORDS-1:0][DATA_W-1:0] words;

   assign words[WORD_BYTES]  = byte_q;
   assign words[WORD_HALVES] = half_q;
   assign words[WORD_FULL]   = {word_hi, 1'b0};

   always_comb begin
      rdata_le = '0;
      if (rd_sel && !oob) begin
         for (int k = 0; k < N_WORDS; k++) begin
            if (wsel[k]) rdata_le = words[k];
         end
      end
   end
endmodule

// File: rtl/npk_apb_regs.sv
`timescale 1ns/1ps
module npk_apb_regs
   import npk_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int HALF_W     = 16,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic                pclk,
   input  logic                presetn,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [DATA_W-1:0]   pwdata,
   input  logic [DATA_W/8-1:0] pstrb,
   output logic [DATA_W-1:0]   prdata,
   output logic                pready,
   output logic                pslverr,
   input  logic                hw_valid,
   input  logic [HALF_W-1:0]   hw_next,
   output logic [DATA_W-1:0]   byte_q,
   output logic [DATA_W-1:0]   half_q,
   output logic [DATA_W-1:0]   word_q
);
   if (DATA_W != BUS_W) begin : g_chk_w
      $error("DATA_W must match the widest register");
   end
   if (HALF_W * N_HALF_REGS != DATA_W) begin : g_chk_h
      $error("half registers must fill one bus word");
   end
   if (ADDR_W < 4) begin : g_chk_a
      $error("ADDR_W too small for the map");
   end

   logic [ADDR_W-3:0]   widx;
   logic                acc_wr, rd_sel, oob;
   logic [DATA_W-1:0]   wdata_le, rdata_le;
   logic [DATA_W/8-1:0] strb_le;
   logic [N_WORDS-1:0]  wsel;
   npk_stb_t            stb;

   npk_busif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_busif (
      .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
      .pwdata(pwdata), .pstrb(pstrb), .rdata_le(rdata_le),
      .widx(widx), .acc_wr(acc_wr), .rd_sel(rd_sel),
      .wdata_le(wdata_le), .strb_le(strb_le), .prdata(prdata)
   );

   npk_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
      .widx(widx), .acc_wr(acc_wr), .strb(strb_le),
      .wsel(wsel), .oob(oob), .stb(stb)
   );

   npk_regs #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_regs (
      .clk(pclk), .rst_n(presetn), .stb(stb), .wdata(wdata_le),
      .hw_valid(hw_valid), .hw_next(hw_next),
      .byte_q(byte_q), .half_q(half_q), .word_q(word_q)
   );

   npk_rdmux #(.DATA_W(DATA_W)) u_rdmux (
      .rd_sel(rd_sel), .oob(oob), .wsel(wsel),
      .byte_q(byte_q), .half_q(half_q), .word_hi(word_q[DATA_W-1:1]),
      .rdata_le(rdata_le)
   );

   assign pready  = 1'b1;
   assign pslverr = psel & penable & oob;
endmodule

// File: rtl/npk_apb_regs_chk.sv
`timescale 1ns/1ps
module npk_apb_regs_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic                pclk,
   input logic                presetn,
   input logic                psel,
   input logic                penable,
   input logic                pwrite,
   input logic [ADDR_W-1:0]   paddr,
   input logic [DATA_W/8-1:0] pstrb,
   input logic                pready,
   input logic                pslverr,
   input logic [DATA_W-1:0]   byte_q,
   input logic [DATA_W-1:0]   word_q
);
   localparam int IW = ADDR_W - 2;
   localparam logic [IW-1:0] LAST_IDX = IW'(2);
   localparam logic [IW-1:0] FULL_IDX = IW'(2);

   logic [IW-1:0] idx;
   logic          acc;
   assign idx = paddr[ADDR_W-1:2];
   assign acc = psel & penable;

   a_r1_always_ready: assert property (@(posedge pclk) disable iff (!presetn)
      pready);

   a_r2_err_out_of_map: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && idx > LAST_IDX) |-> pslverr);

   a_r2_no_err_in_map: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && idx <= LAST_IDX) |-> !pslverr);

   a_r2_oob_write_inert: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && idx > LAST_IDX) |=> ($stable(byte_q) && $stable(word_q[DATA_W-1:1])));

   a_r6_partial_word_inert: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && idx == FULL_IDX && !(&pstrb)) |=> $stable(word_q[DATA_W-1:1]));

   a_r8_pulse_single: assert property (@(posedge pclk) disable iff (!presetn)
      word_q[0] |=> !word_q[0]);
endmodule

bind npk_apb_regs npk_apb_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
   .pwrite(pwrite), .paddr(paddr), .pstrb(pstrb), .pready(pready),
   .pslverr(pslverr), .byte_q(byte_q), .word_q(word_q)
);

// File: tb/npk_apb_regs_bench.sv
`timescale 1ns/1ps
module npk_apb_regs_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  strb = '0;
   logic        hw_valid = 1'b0;
   logic [15:0] hw_next = '0;

   logic [31:0] pwdata_be;
   logic [3:0]  pstrb_be;
   logic [31:0] prdata_le, prdata_be;
   logic        pready_le, pready_be, perr_le, perr_be;
   logic [31:0] bq_le, hq_le, wq_le, bq_be, hq_be, wq_be;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] bswap(logic [31:0] d);
      return {d[7:0], d[15:8], d[23:16], d[31:24]};
   endfunction

   assign pwdata_be = bswap(wdata);
   assign pstrb_be  = {strb[0], strb[1], strb[2], strb[3]};

   npk_apb_regs u_npk_apb_regs (
      .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(wdata), .pstrb(strb), .prdata(prdata_le),
      .pready(pready_le), .pslverr(perr_le), .hw_valid(hw_valid), .hw_next(hw_next),
      .byte_q(bq_le), .half_q(hq_le), .word_q(wq_le)
   );

   npk_apb_regs #(.BIG_ENDIAN(1'b1)) u_npk_apb_regs_be (
      .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata_be), .pstrb(pstrb_be), .prdata(prdata_be),
      .pready(pready_be), .pslverr(perr_be), .hw_valid(hw_valid), .hw_next(hw_next),
      .byte_q(bq_be), .half_q(hq_be), .word_q(wq_be)
   );

   // behavioural reference model
   logic [7:0]  mb [4];
   logic [15:0] mh [2];
   logic [31:1] mw;
   logic        mp;
   wire  [5:0]  widx = paddr[7:2];
   wire         wr   = psel && penable && pwrite;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (mb[i]) mb[i] <= '0;
         foreach (mh[i]) mh[i] <= '0;
         mw <= '0;
         mp <= 1'b0;
      end else begin
         mp <= 1'b0;
         if (hw_valid) mh[1] <= hw_next;
         if (wr) begin
            if (widx == 0) begin
               for (int i = 0; i < 4; i++) if (strb[i]) mb[i] <= wdata[8*i +: 8];
            end else if (widx == 1) begin
               if (strb[1:0] == 2'b11) mh[0] <= wdata[15:0];
               if (strb[3:2] == 2'b11) mh[1] <= wdata[31:16];
            end else if (widx == 2) begin
               if (strb == 4'hF) begin
                  mw <= wdata[31:1];
                  mp <= wdata[0];
               end
            end
         end
      end
   end

   task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      logic [31:0] exp_rd;
      logic        exp_err;
      if (!done) begin
         exp_rd = '0;
         if (psel && !pwrite && widx < 3) begin
            if (widx == 0)      exp_rd = {mb[3], mb[2], mb[1], mb[0]};
            else if (widx == 1) exp_rd = {mh[1], mh[0]};
            else                exp_rd = {mw, 1'b0};
         end
         exp_err = psel && penable && (widx >= 3);
         if (!rst_n) begin
            cmp("R11 byte regs", bq_le, 32'h0);
            cmp("R11 half regs", hq_le, 32'h0);
            cmp("R11 word reg", wq_le, 32'h0);
         end else begin
            cmp("R1 pready", {31'h0, pready_le & pready_be}, 32'h1);
            cmp("R2 pslverr", {30'h0, perr_le, perr_be}, {30'h0, exp_err, exp_err});
            cmp("R4 byte regs", bq_le, {mb[3], mb[2], mb[1], mb[0]});
            cmp("R5 half reg offset 4", {16'h0, hq_le[15:0]}, {16'h0, mh[0]});
            cmp("R9 half reg offset 6", {16'h0, hq_le[31:16]}, {16'h0, mh[1]});
            cmp("R6 word reg", {wq_le[31:1], 1'b0}, {mw, 1'b0});
            cmp("R8 pulse", {31'h0, wq_le[0]}, {31'h0, mp});
            cmp("R7 prdata", prdata_le, exp_rd);
            cmp("R10 prdata swapped", prdata_be, bswap(exp_rd));
            cmp("R10 state equal", bq_be ^ bq_le ^ hq_be ^ hq_le, 32'h0);
            cmp("R10 word equal", wq_be, wq_le);
         end
      end
   end

   task automatic apb(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
      @(posedge clk); #1;
      psel = 1; penable = 0; pwrite = w; paddr = a; wdata = d; strb = s;
      @(posedge clk); #1;
      penable = 1;
      @(posedge clk); #1;
      psel = 0; penable = 0; pwrite = 0; strb = '0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R4: all four byte registers in one access, then sparse strobes
      apb(1, 8'h00, 32'h11223344, 4'hF);
      apb(0, 8'h00, 32'h0, 4'h0);
      apb(1, 8'h00, 32'hAABBCCDD, 4'b0101);
      apb(0, 8'h00, 32'h0, 4'h0);
      // R3: misaligned byte address selects its word
      apb(1, 8'h03, 32'h0000EE00, 4'b0010);
      apb(0, 8'h02, 32'h0, 4'h0);
      // R5: half registers need both strobes
      apb(1, 8'h04, 32'h0000BEEF, 4'b0011);
      apb(1, 8'h05, 32'h12340000, 4'b0100);
      apb(1, 8'h04, 32'hCAFE0000, 4'b1100);
      apb(1, 8'h06, 32'h99998888, 4'b1001);
      apb(0, 8'h07, 32'h0, 4'h0);
      // R9: hardware load, then collision with software write
      @(posedge clk); #1 hw_valid = 1; hw_next = 16'h5A5A;
      @(posedge clk); #1 hw_valid = 0;
      apb(0, 8'h04, 32'h0, 4'h0);
      hw_valid = 1; hw_next = 16'h1111;
      apb(1, 8'h04, 32'h77770000, 4'b1100);
      hw_valid = 0;
      apb(0, 8'h04, 32'h0, 4'h0);
      // R6 / R8: partial write ignored, full write with pulse
      apb(1, 8'h08, 32'hFFFFFFFF, 4'b0111);
      apb(1, 8'h08, 32'hDEADBEE1, 4'hF);
      apb(0, 8'h0B, 32'h0, 4'h0);
      apb(1, 8'h09, 32'h01234566, 4'hF);
      // R2: out-of-range accesses
      apb(1, 8'h0C, 32'hFFFFFFFF, 4'hF);
      apb(0, 8'h10, 32'h0, 4'h0);
      apb(1, 8'hFC, 32'h5555AAAA, 4'hF);
      // R11: asynchronous reset mid-run
      @(posedge clk); #3 rst_n = 0;
      @(posedge clk); #1 rst_n = 1;
      apb(0, 8'h00, 32'h0, 4'h0);
      apb(0, 8'h04, 32'h0, 4'h0);
      apb(0, 8'h08, 32'h0, 4'h0);
      apb(1, 8'h00, 32'h0F0E0D0C, 4'b1010);
      apb(0, 8'h01, 32'h0, 4'h0);
      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule